// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and date in packed BCD: seconds, minutes, hours (24-hour), day of month, weekday, month and a two-digit year, plus a century flag that flips each time the year wraps. An internal prescaler counts pulses of a slow-oscillator enable input. Once every `PRESC_DIV` pulses it issues a one-second step, which ripples through the fields. The day of month follows the length of the current month, including leap years.

Software uses a byte-wide register port with an address, write data, a write strobe and combinational read data. A halt bit freezes the calendar so that software can load the fields one by one. A validity flag in the seconds byte starts out set after reset and shows that the time has not yet been written. All fields change on the same clock edge, so a read never sees a half-updated carry. If a second step falls in a cycle that carries a register write, the step is held over and applied in the next cycle.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the registers read: control 0x00, seconds 0x80 (validity flag set, 00 s), minutes 0x00, hours 0x00, day 0x01, weekday 0x00, month 0x01 (century flag clear), year 0x00.
- R2: Register layout: 0x00 control with the halt bit at bit 5; 0x02 seconds (bits 6:0) with the validity flag at bit 7; 0x03 minutes (6:0); 0x04 hours (5:0); 0x05 day (5:0); 0x06 weekday (2:0, 0 = Sunday); 0x07 month (4:0, BCD 1 to 12) with the century flag at bit 7; 0x08 year (7:0, BCD 00 to 99). Unused bits and unmapped addresses read zero.
- R3: Each group of `PRESC_DIV` oscillator pulses advances the seconds by one BCD step. Seconds and minutes wrap 59 to 00, and hours wrap 23 to 00, each carrying into the next field.
- R4: At the end of a day the day of month goes to 01 after day 31 (months 1, 3, 5, 7, 8, 10, 12), day 30 (months 4, 6, 9, 11), day 29 (February, year divisible by 4) or day 28 (other Februaries). The month then steps, and December wraps to January and steps the year.
- R5: The weekday steps once per day boundary and wraps from 6 to 0.
- R6: A year wrap from 99 to 00 toggles the century flag. Nothing else changes it except a write to the month register.
- R7: While the halt bit is set no field changes and the prescaler is held cleared. After the bit is cleared, the first seconds step comes exactly `PRESC_DIV` pulses later.
- R8: The validity flag is set by reset. It takes bit 7 of every write to the seconds register. Second steps and writes to other registers leave it unchanged.
- R9: A second step that lands in a cycle with a register write is not lost. It is applied one cycle later, on top of the written value.
- R10: A write loads the addressed field, masked to its width, on the next clock edge. Writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-cycle pulse per slow-oscillator period |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |

## Verification
The step assertions assume that software writes only legal BCD values, each within its field's range. The range checks and the wrap-to-base checks are meaningful only under that assumption. The stimulus draws every random time and date from legal ranges. It sets the day within the length of the target month before any time passes, and it biases the values toward 59 seconds, 59 minutes, 23 hours and month-end days so that the carries happen often. Directed cases cover the century wrap, leap and common Februaries, the halt window with a part-counted prescaler, and a write that collides with a step.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
   typedef logic [7:0] bcd8_t;

   localparam int unsigned NUM_FLD  = 7;
   localparam int unsigned FLD_BASE = 2;
   localparam int unsigned A_CTRL   = 0;
   localparam int unsigned A_SEC    = 2;
   localparam int unsigned A_MON    = 7;
   localparam int unsigned HALT_BIT = 5;
   localparam int unsigned FLAG_BIT = 7;

   // field order: sec, min, hour, day, weekday, month, year
   localparam int unsigned FLD_W   [NUM_FLD] = '{7, 7, 6, 6, 3, 5, 8};
   localparam int unsigned FLD_LOW [NUM_FLD] = '{0, 0, 0, 1, 0, 1, 0};

   function automatic bcd8_t bcd_next(bcd8_t v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic leap_yr(bcd8_t y);
      logic [7:0] b;
      b = {4'b0, y[7:4]} * 8'd10 + {4'b0, y[3:0]};
      return b[1:0] == 2'b00;
   endfunction

   function automatic bcd8_t month_days(bcd8_t mon, bcd8_t y);
      case (mon)
         8'h02:                      return leap_yr(y) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction
endpackage

// File: rtl/cal_prescaler.sv
`timescale 1ns/1ps
module cal_prescaler #(
   parameter int unsigned DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic osc_en,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_pass
         assign tick = osc_en & ~hold;
      end else begin : g_cnt
         localparam int unsigned CW = $clog2(DIV);
         logic [CW-1:0] cnt_q;
         logic          last;
         assign last = (cnt_q == CW'(DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= '0;
            else if (hold)   cnt_q <= '0;
            else if (osc_en) cnt_q <= last ? '0 : cnt_q + 1'b1;
         end
         assign tick = osc_en & ~hold & last;
      end
   endgenerate
endmodule

// File: rtl/cal_bcd_field.sv
`timescale 1ns/1ps
module cal_bcd_field #(
   parameter int unsigned W   = 7,
   parameter int unsigned LOW = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic [7:0]   top_val,
   output logic [W-1:0] val,
   output logic         wrap
);
   logic [7:0] nxt;
   assign nxt  = cal_pkg::bcd_next(8'(val));
   assign wrap = inc & (8'(val) >= top_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val <= W'(LOW);
      else if (ld)  val <= ld_val;
      else if (inc) val <= wrap ? W'(LOW) : nxt[W-1:0];
   end
endmodule

// File: rtl/bcd_calendar.sv
`timescale 1ns/1ps
module bcd_calendar
   import cal_pkg::*;
#(
   parameter int unsigned PRESC_DIV = 32768,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_we,
   output logic [DATA_W-1:0] reg_rdata
);
   generate
      if (DATA_W != 8) begin : g_chk_dw
         $error("bcd_calendar: DATA_W must be 8");
      end
      if (ADDR_W < 4) begin : g_chk_aw
         $error("bcd_calendar: ADDR_W must be at least 4");
      end
      if (PRESC_DIV < 1) begin : g_chk_div
         $error("bcd_calendar: PRESC_DIV must be at least 1");
      end
   endgenerate

   logic halt_q, flag_q, cent_q, pend_q;
   logic tick, adv;
   logic [7:0] val8  [NUM_FLD];
   logic [7:0] top_v [NUM_FLD];
   logic [NUM_FLD-1:0] inc_v, wrap_v, fld_we;
   logic we_ctrl, we_sec, we_mon;

   assign we_ctrl = reg_we && (reg_addr == ADDR_W'(A_CTRL));
   assign we_sec  = reg_we && (reg_addr == ADDR_W'(A_SEC));
   assign we_mon  = reg_we && (reg_addr == ADDR_W'(A_MON));

   cal_prescaler #(.DIV(PRESC_DIV)) u_presc (
      .clk(clk), .rst_n(rst_n), .hold(halt_q), .osc_en(osc_en), .tick(tick)
   );

   // a step colliding with a write waits one cycle
   assign adv = (tick | pend_q) & ~reg_we & ~halt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q <= 1'b0;
         flag_q <= 1'b1;
         cent_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         pend_q <= (tick | pend_q) & reg_we & ~halt_q;
         if (we_ctrl) halt_q <= reg_wdata[HALT_BIT];
         if (we_sec)  flag_q <= reg_wdata[FLAG_BIT];
         if (we_mon)          cent_q <= reg_wdata[FLAG_BIT];
         else if (wrap_v[6])  cent_q <= ~cent_q;
      end
   end

   // carry chain: sec -> min -> hour -> (day, weekday); day -> month -> year
   always_comb begin
      inc_v[0] = adv;
      inc_v[1] = wrap_v[0];
      inc_v[2] = wrap_v[1];
      inc_v[3] = wrap_v[2];
      inc_v[4] = wrap_v[2];
      inc_v[5] = wrap_v[3];
      inc_v[6] = wrap_v[5];
   end

   always_comb begin
      top_v[0] = 8'h59;
      top_v[1] = 8'h59;
      top_v[2] = 8'h23;
      top_v[3] = month_days(val8[5], val8[6]);
      top_v[4] = 8'h06;
      top_v[5] = 8'h12;
      top_v[6] = 8'h99;
   end

   generate
      for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
         localparam int unsigned W = FLD_W[i];
         logic [W-1:0] fv;
         assign fld_we[i] = reg_we && (reg_addr == ADDR_W'(FLD_BASE + i));
         cal_bcd_field #(.W(W), .LOW(FLD_LOW[i])) u_fld (
            .clk(clk), .rst_n(rst_n), .inc(inc_v[i]), .ld(fld_we[i]),
            .ld_val(reg_wdata[W-1:0]), .top_val(top_v[i]),
            .val(fv), .wrap(wrap_v[i])
         );
         assign val8[i] = 8'(fv);
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(A_CTRL): reg_rdata = 8'(halt_q) << HALT_BIT;
         ADDR_W'(2):      reg_rdata = val8[0] | {flag_q, 7'b0};
         ADDR_W'(3):      reg_rdata = val8[1];
         ADDR_W'(4):      reg_rdata = val8[2];
         ADDR_W'(5):      reg_rdata = val8[3];
         ADDR_W'(6):      reg_rdata = val8[4];
         ADDR_W'(7):      reg_rdata = val8[5] | {cent_q, 7'b0};
         ADDR_W'(8):      reg_rdata = val8[6];
         default:         reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/cal_checker.sv
`timescale 1ns/1ps
module cal_checker #(
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              we,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        wdata,
   input logic [7:0]        sec,
   input logic [7:0]        min,
   input logic [7:0]        day,
   input logic [7:0]        wday,
   input logic [7:0]        mon,
   input logic [7:0]        year,
   input logic              cent,
   input logic              flag,
   input logic              halt
);
   import cal_pkg::*;

   AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !we) |=> ($stable(sec) && $stable(min) && $stable(day) && $stable(wday)
                         && $stable(mon) && $stable(year) && $stable(cent))); // R7

   AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && addr == ADDR_W'(A_SEC)) |=> $stable(flag)); // R8

   AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> (sec == $past(sec)) ||
              (sec == (($past(sec) == 8'h59) ? 8'h00 : bcd_next($past(sec))))); // R3

   AST_CENT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && addr == ADDR_W'(A_MON)) |=>
         (cent == $past(cent)) || ($past(year) == 8'h99 && year == 8'h00)); // R6

   AST_DAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> (day == $past(day)) || (day == bcd_next($past(day))) || (day == 8'h01)); // R4

   AST_WDAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> (wday == $past(wday)) || (wday == $past(wday) + 8'd1) ||
              ($past(wday) == 8'h06 && wday == 8'h00)); // R5

   AST_MIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADDR_W'(3)) |=> (min == {1'b0, $past(wdata[6:0])})); // R10
endmodule

bind bcd_calendar cal_checker #(.ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
   .sec(val8[0]), .min(val8[1]), .day(val8[3]), .wday(val8[4]),
   .mon(val8[5]), .year(val8[6]), .cent(cent_q), .flag(flag_q), .halt(halt_q)
);

// File: tb/bcd_calendar_tb_top.sv
`timescale 1ns/1ps
module bcd_calendar_tb_top;
   localparam int unsigned DIV = 4;

   logic       clk = 1'b0, rst_n = 1'b0, osc_en = 1'b0, we = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;

   always #2.5 clk = ~clk;

   bcd_calendar #(.PRESC_DIV(DIV)) dut_i (
      .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .reg_addr(addr),
      .reg_wdata(wdata), .reg_we(we), .reg_rdata(rdata)
   );

   int n_chk = 0, n_fail = 0;
   int s, m, h, d, w, mo, y, c, vl;

   function automatic logic [7:0] bcd(int v);
      return 8'(((v / 10) * 16) + (v % 10));
   endfunction

   function automatic int mlen(int mon, int yr);
      if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
      end
   endtask

   task automatic rd(int a, output logic [7:0] v);
      @(negedge clk);
      addr = 4'(a);
      #1 v = rdata;
   endtask

   task automatic wr(int a, logic [7:0] v);
      @(negedge clk);
      addr = 4'(a); wdata = v; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic run_cyc(int n);
      @(negedge clk);
      osc_en = 1'b1;
      repeat (n) @(negedge clk);
      osc_en = 1'b0;
   endtask

   task automatic model_step();
      s++;
      if (s == 60) begin
         s = 0; m++;
         if (m == 60) begin
            m = 0; h++;
            if (h == 24) begin
               h = 0; w = (w + 1) % 7; d++;
               if (d > mlen(mo, y)) begin
                  d = 1; mo++;
                  if (mo == 13) begin
                     mo = 1; y++;
                     if (y == 100) begin y = 0; c = 1 - c; end
                  end
               end
            end
         end
      end
   endtask

   task automatic run_secs(int n);
      run_cyc(n * int'(DIV));
      for (int i = 0; i < n; i++) model_step();
   endtask

   task automatic load_all();
      wr(8, bcd(y));
      wr(7, bcd(mo) | (c != 0 ? 8'h80 : 8'h00));
      wr(5, bcd(d));
      wr(6, bcd(w));
      wr(4, bcd(h));
      wr(3, bcd(m));
      wr(2, bcd(s) | (vl != 0 ? 8'h80 : 8'h00));
   endtask

   task automatic compare_all(string tag);
      logic [7:0] v;
      rd(2, v); check({tag, " sec"},  v, bcd(s) | (vl != 0 ? 8'h80 : 8'h00));
      rd(3, v); check({tag, " min"},  v, bcd(m));
      rd(4, v); check({tag, " hour"}, v, bcd(h));
      rd(5, v); check({tag, " day"},  v, bcd(d));
      rd(6, v); check({tag, " wday"}, v, bcd(w));
      rd(7, v); check({tag, " mon"},  v, bcd(mo) | (c != 0 ? 8'h80 : 8'h00));
      rd(8, v); check({tag, " year"}, v, bcd(y));
   endtask

   task automatic set_time(int ny, int nmo, int nd, int nw, int nh, int nm, int ns, int nc);
      y = ny; mo = nmo; d = nd; w = nw; h = nh; m = nm; s = ns; c = nc; vl = 0;
      load_all();
   endtask

   task automatic run_all();
      logic [7:0] v;
      s = 0; m = 0; h = 0; d = 1; w = 0; mo = 1; y = 0; c = 0; vl = 1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R2 reset state and layout
      rd(0, v); check("R1 ctrl", v, 8'h00);
      rd(1, v); check("R2 unmapped 0x01", v, 8'h00);
      compare_all("R1 reset");

      // R3 prescaler period, R8 flag kept over steps
      run_cyc(DIV - 1);
      rd(2, v); check("R3 before step", v, 8'h80);
      run_cyc(1); model_step();
      rd(2, v); check("R3 R8 after step", v, 8'h81);

      // R8 flag follows writes to seconds only
      wr(2, 8'h00); vl = 0; s = 0;
      rd(2, v); check("R8 flag cleared", v, 8'h00);
      wr(3, 8'h80); m = 0;
      rd(2, v); check("R8 other write", v, 8'h00);
      wr(2, 8'h92); vl = 1; s = 12;
      rd(2, v); check("R8 flag set by write", v, 8'h92);
      wr(2, 8'h12); vl = 0;

      // R10 unmapped writes ignored, masking of fields
      wr(1, 8'hFF); wr(9, 8'hFF); wr(15, 8'hFF);
      rd(0, v); check("R10 ctrl after unmapped", v, 8'h00);
      compare_all("R10 unmapped");
      wr(4, 8'hE3); h = 23;
      rd(4, v); check("R10 hour masked", v, 8'h23);

      // R7 halt with a part-counted prescaler
      set_time(24, 5, 10, 3, 8, 30, 20, 0);
      run_cyc(2);
      wr(0, 8'h20);
      rd(0, v); check("R7 R2 halt bit", v, 8'h20);
      run_cyc(3 * DIV);
      compare_all("R7 halted");
      wr(0, 8'h00);
      run_cyc(DIV - 1);
      rd(2, v); check("R7 no early step", v, bcd(s));
      run_cyc(1); model_step();
      compare_all("R7 resumed");

      // R9 write colliding with a step
      set_time(24, 5, 10, 3, 8, 30, 10, 0);
      run_cyc(DIV - 1);
      @(negedge clk);
      osc_en = 1'b1; we = 1'b1; addr = 4'(3); wdata = 8'h33;
      @(negedge clk);
      osc_en = 1'b0; we = 1'b0; addr = 4'(2);
      #1 check("R9 step deferred", rdata, bcd(10));
      @(negedge clk);
      #1 check("R9 step applied", rdata, bcd(11));
      m = 33; s = 11;
      compare_all("R9 after");

      // R6 R4 R5 century wrap
      set_time(99, 12, 31, 6, 23, 59, 59, 0);
      run_secs(1);
      compare_all("R6 R4 R5 century");
      set_time(99, 12, 31, 2, 23, 59, 59, 1);
      run_secs(1);
      compare_all("R6 century back");
      // R4 month lengths
      set_time(24, 2, 28, 1, 23, 59, 59, 0); run_secs(1); compare_all("R4 leap feb28");
      run_secs(86400 / 86400); compare_all("R4 leap feb29 +1s");
      set_time(24, 2, 29, 1, 23, 59, 59, 0); run_secs(1); compare_all("R4 leap feb29");
      set_time(23, 2, 28, 1, 23, 59, 59, 0); run_secs(1); compare_all("R4 common feb");
      set_time(0, 2, 28, 1, 23, 59, 59, 0);  run_secs(1); compare_all("R4 year00 feb");
      set_time(24, 4, 30, 1, 23, 59, 59, 0); run_secs(1); compare_all("R4 apr30");
      set_time(24, 1, 31, 1, 23, 59, 59, 0); run_secs(1); compare_all("R4 jan31");
      set_time(24, 11, 30, 5, 23, 59, 59, 0); run_secs(1); compare_all("R4 nov30");

      // random trials, biased toward carries (R3 R4 R5)
      for (int t = 0; t < 30; t++) begin
         int l;
         y  = ($urandom % 4 == 0) ? 99 : int'($urandom % 100);
         mo = 1 + int'($urandom % 12);
         l  = mlen(mo, y);
         d  = ($urandom % 2 == 1) ? l : 1 + int'($urandom % l);
         w  = int'($urandom % 7);
         h  = ($urandom % 2 == 1) ? 23 : int'($urandom % 24);
         m  = ($urandom % 2 == 1) ? 59 : int'($urandom % 60);
         s  = 50 + int'($urandom % 10);
         c  = int'($urandom % 2);
         vl = 0;
         load_all();
         compare_all("R10 random load");
         run_secs(1 + int'($urandom % 20));
         compare_all("R3 R4 R5 random run");
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog (R1..all): actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule